// File: doc/BRIEF.md
# Half-Bridge Complementary PWM With Dead Band

This block drives the two gate lines of one half-bridge phase. Every period opens with a band where both switches are off. The high-side switch then conducts, a second off band follows, and the low-side switch conducts for the same number of cycles. Because both conduction phases use the same count, the pulse is centred in the period and the waveform is symmetric.

The conduction count for each period arrives through a small write FIFO. At the start of a period the sequencer takes the oldest queued count if one is waiting. If none is waiting, it reuses the count from the previous period, so software or a stream engine only needs to write when the duty changes.

A shared start input lets several copies begin on the same clock. Phases of a multi-phase bridge can then be aligned by wiring one start strobe to all of them. Fault shutdown, converter triggering and duty computation are handled outside the block.

Top module: `halfbridge_pwm`

## Requirements
- R1: The outputs `gate_hi` and `gate_lo` are never 1 in the same cycle. The pair {gate_hi,gate_lo} reads 2'b10 when the high side conducts, 2'b01 when the low side conducts and 2'b00 when both are off.
- R2: While reset is high, and after it is released, both outputs stay 0 until `start` is sampled high.
- R3: Once running, each period repeats this order: off band, high-side conduction, off band, low-side conduction. The outputs never switch directly from one conducting side to the other.
- R4: The off band that opens a period lasts DT+3 cycles: two count-refresh cycles plus DT+1 dead cycles. The off band between high-side and low-side conduction lasts exactly DT+1 cycles.
- R5: With conduction count c, the high-side phase and the low-side phase each last c+2 cycles. Within one period the two lengths are equal.
- R6: In the first cycle of a period, the oldest queued count is loaded if the FIFO is not empty. Otherwise the previous count is kept. Before any count has been written, the count is INIT_COUNT.
- R7: The FIFO holds DEPTH counts and serves them in write order. `cnt_ready` is 0 while it is full, and a write offered while it is full is dropped.
- R8: When `start` is sampled high in the idle state, the first period begins on the next cycle, and the first high-side pulse starts DT+3 cycles after that. Copies sharing `start` switch their high side on in the same cycle. Once the block is running, `start` has no effect.
- R9: The full count range works: a count of 2^CNT_W-1 gives conduction phases of 2^CNT_W+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_valid | input | 1 | Write strobe for a conduction count |
| cnt_data | input | CNT_W | Conduction count to queue |
| cnt_ready | output | 1 | FIFO has space; low when full |
| start | input | 1 | Shared start flag; begins the first period |
| gate_hi | output | 1 | High-side gate drive, registered |
| gate_lo | output | 1 | Low-side gate drive, registered |

## Verification
The hardest case to reach is the moment when the queue runs dry and the count must silently persist, followed by a fresh count arriving mid-period. The fresh count has to be picked up at the next period and not the current one. The stimulus fills the FIFO to full before start, offers an extra write that must be dropped, lets the queued counts drain, and then writes a new count only after observing the fifth rising edge of the high-side output. Every expected segment length is then known in advance. A second copy with an empty FIFO shares the start strobe so that alignment of the first high-side edge can be compared.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_FETCH  = 3'd1,
    PH_LOAD   = 3'd2,
    PH_DEAD_A = 3'd3,
    PH_HIGH   = 3'd4,
    PH_DEAD_B = 3'd5,
    PH_LOW    = 3'd6
  } phase_t;

  // Gate pair encoding {high, low}
  function automatic logic [1:0] gate_code(input phase_t ph);
    case (ph)
      PH_HIGH: gate_code = 2'b10;
      PH_LOW:  gate_code = 2'b01;
      default: gate_code = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/pwm_cnt_fifo.sv
module pwm_cnt_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULLV = (AW + 1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   used;
  logic          do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign empty   = (used == '0);
  assign full    = (used == FULLV);
  assign head    = mem[rp];

  // Storage has no reset so it maps onto plain RAM.
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      used <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   used <= used + 1'b1;
        2'b01:   used <= used - 1'b1;
        default: used <= used;
      endcase
    end
  end

endmodule

// File: rtl/pwm_sequencer.sv
module pwm_sequencer
  import pwm_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DT         = 3,
  parameter int INIT_COUNT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             q_empty,
  input  logic [CNT_W-1:0] q_head,
  output logic             q_pop,
  output phase_t           phase_next
);

  localparam int DW = $clog2(DT + 2);
  localparam int TW = ((CNT_W + 1) > DW) ? (CNT_W + 1) : DW;
  localparam logic [TW-1:0] DEAD_LOAD = TW'(DT);

  phase_t           phase_q;
  logic [CNT_W-1:0] count_q, count_d;
  logic [TW-1:0]    timer_q, timer_d;
  logic [TW-1:0]    cond_load;
  logic             tzero;

  assign tzero     = (timer_q == '0);
  assign cond_load = TW'(count_q) + TW'(1);

  always_comb begin
    phase_next = phase_q;
    timer_d    = timer_q;
    count_d    = count_q;
    q_pop      = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start) phase_next = PH_FETCH;
      end
      PH_FETCH: begin
        if (!q_empty) begin
          q_pop   = 1'b1;
          count_d = q_head;
        end
        phase_next = PH_LOAD;
      end
      PH_LOAD: begin
        timer_d    = DEAD_LOAD;
        phase_next = PH_DEAD_A;
      end
      PH_DEAD_A: begin
        if (tzero) begin
          timer_d    = cond_load;
          phase_next = PH_HIGH;
        end else begin
          timer_d = timer_q - 1'b1;
        end
      end
      PH_HIGH: begin
        if (tzero) begin
          timer_d    = DEAD_LOAD;
          phase_next = PH_DEAD_B;
        end else begin
          timer_d = timer_q - 1'b1;
        end
      end
      PH_DEAD_B: begin
        if (tzero) begin
          timer_d    = cond_load;
          phase_next = PH_LOW;
        end else begin
          timer_d = timer_q - 1'b1;
        end
      end
      PH_LOW: begin
        if (tzero) begin
          phase_next = PH_FETCH;
        end else begin
          timer_d = timer_q - 1'b1;
        end
      end
      default: phase_next = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      timer_q <= '0;
      count_q <= CNT_W'(INIT_COUNT);
    end else begin
      phase_q <= phase_next;
      timer_q <= timer_d;
      count_q <= count_d;
    end
  end

endmodule

// File: rtl/pwm_gate_out.sv
module pwm_gate_out
  import pwm_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t phase_next,
  output logic   gate_hi,
  output logic   gate_lo
);

  logic [1:0] code;
  assign code = gate_code(phase_next);

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else begin
      gate_hi <= code[1];
      gate_lo <= code[0];
    end
  end

endmodule

// File: rtl/halfbridge_pwm.sv
module halfbridge_pwm
  import pwm_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DT         = 3,
  parameter int DEPTH      = 4,
  parameter int INIT_COUNT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_valid,
  input  logic [CNT_W-1:0] cnt_data,
  output logic             cnt_ready,
  input  logic             start,
  output logic             gate_hi,
  output logic             gate_lo
);

  logic             q_empty, q_full, q_pop;
  logic [CNT_W-1:0] q_head;
  phase_t           phase_next;

  assign cnt_ready = !q_full;

  pwm_cnt_fifo #(.W(CNT_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (cnt_valid),
    .push_data (cnt_data),
    .pop       (q_pop),
    .head      (q_head),
    .empty     (q_empty),
    .full      (q_full)
  );

  pwm_sequencer #(.CNT_W(CNT_W), .DT(DT), .INIT_COUNT(INIT_COUNT)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .q_empty    (q_empty),
    .q_head     (q_head),
    .q_pop      (q_pop),
    .phase_next (phase_next)
  );

  pwm_gate_out u_out (
    .clk        (clk),
    .rst        (rst),
    .phase_next (phase_next),
    .gate_hi    (gate_hi),
    .gate_lo    (gate_lo)
  );

endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
  parameter int DT = 3
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic gate_hi,
  input logic gate_lo
);

  logic        seen_start;
  logic [15:0] off_run;
  logic [31:0] hi_len, lo_len;
  logic        hi_d, lo_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_start <= 1'b0;
      off_run    <= '0;
      hi_len     <= '0;
      lo_len     <= '0;
      hi_d       <= 1'b0;
      lo_d       <= 1'b0;
    end else begin
      hi_d <= gate_hi;
      lo_d <= gate_lo;
      if (start) seen_start <= 1'b1;
      if (!gate_hi && !gate_lo) off_run <= (off_run == 16'hFFFF) ? off_run : off_run + 1'b1;
      else                      off_run <= '0;
      if (gate_hi) hi_len <= hi_d ? hi_len + 1 : 32'd1;
      if (gate_lo) lo_len <= lo_d ? lo_len + 1 : 32'd1;
    end
  end

  // R1: sides exclusive
  a_r1_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(gate_hi && gate_lo));

  // R2: reset forces outputs off
  a_r2_reset_off: assert property (@(posedge clk)
    rst |=> (!gate_hi && !gate_lo));

  // R2: nothing conducts before start is seen
  a_r2_idle_off: assert property (@(posedge clk) disable iff (rst)
    !seen_start |-> (!gate_hi && !gate_lo));

  // R3: no direct switch from one side to the other
  a_r3_lo_to_hi: assert property (@(posedge clk) disable iff (rst)
    gate_lo |=> !gate_hi);
  a_r3_hi_to_lo: assert property (@(posedge clk) disable iff (rst)
    gate_hi |=> !gate_lo);

  // R4: every off band lasts at least DT+1 cycles
  a_r4_dead_min: assert property (@(posedge clk) disable iff (rst)
    ($rose(gate_hi) || $rose(gate_lo)) |-> (off_run >= 16'(DT + 1)));

  // R5: low-side run equals the preceding high-side run
  a_r5_symmetric: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_lo) |-> (lo_len == hi_len));

endmodule

bind halfbridge_pwm pwm_checker #(.DT(DT)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .gate_hi (gate_hi),
  .gate_lo (gate_lo)
);

// File: tb/halfbridge_pwm_tb.sv
module halfbridge_pwm_tb;

  localparam int CNT_W = 8;
  localparam int DT    = 2;
  localparam int DEPTH = 4;

  typedef struct {
    logic [1:0] pat;
    int         len;
    string      req;
  } seg_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cnt_valid = 1'b0;
  logic [CNT_W-1:0] cnt_data = '0;
  logic             start = 1'b0;
  logic             cnt_ready, gate_hi, gate_lo;
  logic             cnt_ready2, gate_hi2, gate_lo2;

  int   checks = 0;
  int   errors = 0;
  bit   mon_en = 1'b0;
  bit   done   = 1'b0;
  int   cyc    = 0;
  int   first_hi1 = -1;
  int   first_hi2 = -1;
  int   hi_rises  = 0;
  seg_t exp_q[$];

  always #2.5 clk = ~clk;

  halfbridge_pwm #(.CNT_W(CNT_W), .DT(DT), .DEPTH(DEPTH), .INIT_COUNT(0)) u_dut (
    .clk(clk), .rst(rst), .cnt_valid(cnt_valid), .cnt_data(cnt_data),
    .cnt_ready(cnt_ready), .start(start), .gate_hi(gate_hi), .gate_lo(gate_lo));

  halfbridge_pwm #(.CNT_W(CNT_W), .DT(DT), .DEPTH(DEPTH), .INIT_COUNT(0)) u_dut2 (
    .clk(clk), .rst(rst), .cnt_valid(1'b0), .cnt_data('0),
    .cnt_ready(cnt_ready2), .start(start), .gate_hi(gate_hi2), .gate_lo(gate_lo2));

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic push_period(input int c);
    exp_q.push_back('{2'b00, DT + 3, "R4"});
    exp_q.push_back('{2'b10, c + 2,  "R5"});
    exp_q.push_back('{2'b00, DT + 1, "R4"});
    exp_q.push_back('{2'b01, c + 2,  "R5"});
  endtask

  task automatic write_cnt(input int v);
    @(negedge clk);
    cnt_valid = 1'b1;
    cnt_data  = CNT_W'(v);
    @(negedge clk);
    cnt_valid = 1'b0;
  endtask

  // Monitor: measures output runs and compares them with the queue
  initial begin
    logic [1:0] cur;
    int         run;
    bit         have;
    have = 1'b0;
    run  = 0;
    cur  = 2'b00;
    forever begin
      @(negedge clk);
      if (mon_en && !done) begin
        logic [1:0] p;
        p = {gate_hi, gate_lo};
        check(p != 2'b11, "R1", int'(p), 0);
        if (gate_hi  && first_hi1 < 0) first_hi1 = cyc;
        if (gate_hi2 && first_hi2 < 0) first_hi2 = cyc;
        if (!have) begin
          cur = p; run = 1; have = 1'b1;
        end else if (p == cur) begin
          run++;
        end else begin
          if (exp_q.size() > 0) begin
            seg_t e;
            e = exp_q.pop_front();
            check(cur == e.pat, {e.req, "/R3 pattern"}, int'(cur), int'(e.pat));
            check(run == e.len, {e.req, " length"}, run, e.len);
          end
          if (p == 2'b10) hi_rises++;
          cur = p; run = 1;
        end
        cyc++;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Driver
  initial begin
    repeat (4) @(negedge clk);
    check(!gate_hi && !gate_lo, "R2 in reset", int'({gate_hi, gate_lo}), 0);
    rst = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!gate_hi && !gate_lo, "R2 idle", int'({gate_hi, gate_lo}), 0);
    end
    check(cnt_ready == 1'b1, "R7 ready when empty", int'(cnt_ready), 1);
    write_cnt(3);
    write_cnt(5);
    write_cnt(0);
    write_cnt(255);
    check(cnt_ready == 1'b0, "R7 not ready when full", int'(cnt_ready), 0);
    write_cnt(77);   // R7: dropped, FIFO full
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!gate_hi && !gate_lo, "R2 idle after writes", int'({gate_hi, gate_lo}), 0);
    end
    // R6, R9: queued counts in order, then reuse, then a late write
    push_period(3);
    push_period(5);
    push_period(0);
    push_period(255);
    push_period(255);
    push_period(9);
    push_period(9);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1;
    start  = 1'b0;
    mon_en = 1'b1;
    // R8: start pulses while running are ignored
    while (hi_rises < 2) @(negedge clk);
    start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    check(cnt_ready == 1'b1, "R7 space after pops", int'(cnt_ready), 1);
    // R6: new count written during the fifth high-side phase
    while (hi_rises < 5) @(negedge clk);
    write_cnt(9);
    while (exp_q.size() > 0) @(negedge clk);
    check(first_hi1 == DT + 3, "R8 first pulse delay", first_hi1, DT + 3);
    check(first_hi2 == first_hi1, "R8 aligned copies", first_hi2, first_hi1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule